// File: doc/BRIEF.md
# Four-Lane Deskew Aligner

This block sits behind four receive lanes whose character boundaries are already found, and removes the relative delay between the lanes. Each lane passes through its own tapped delay line, and the tap is chosen per lane. When lock mode is enabled, the block waits for the first data character after each lane's run of comma characters. It records how many cycles each lane lags the earliest one. If the latest lane reports within the allowed window, it sets the taps so that those first data characters leave all four lanes in the same clock cycle. All outputs are timed by the one clock that drives the block.

Once alignment is declared, the taps stay fixed until lock mode is withdrawn. This way a stray comma or first-data marker caused by a bit error cannot disturb an aligned link. If the window runs out, a one-cycle failure pulse is raised, the taps are left at their previous values and the search starts over. With lock mode off, every lane runs at minimum delay and is fully independent of the others.

Top module: `quad_lane_deskew`

## Requirements
- R1: With `lock_en` low, every lane's output equals that lane's input from the previous cycle, first-data markers have no effect, and `deskew_ok` stays low.
- R2: After a successful measurement, the lane whose first data arrived last has the minimum delay of one cycle. Every other lane is delayed by one extra cycle for each cycle it led. The first data characters of all lanes appear on the outputs in the same cycle, one cycle after the last lane presented its first data.
- R3: The measurement succeeds only if the last lane's first data arrives at most WINDOW-1 (4) cycles after the first lane's. `deskew_ok` rises in the same cycle that the aligned first data characters appear.
- R4: If WINDOW cycles pass from the first lane's marker without all lanes reporting, `deskew_fail` is high for exactly one cycle, `deskew_ok` stays low and all lane delays keep their previous values.
- R5: While aligned and `lock_en` stays high, the lane delays do not change, and further first-data markers are ignored.
- R6: One cycle after `lock_en` falls, `deskew_ok` is low and every lane is back at minimum delay.
- R7: While `freeze` is high and no measurement is running, first-data markers do not start a measurement: neither `deskew_ok` nor `deskew_fail` is raised and the delays stay unchanged.
- R8: After a synchronous reset (`rst_n` low at a clock edge), all output data and valid bits are zero and both flags are low.
- R9: The valid bit travels through each delay line together with its character. A first-data marker counts only when that lane's valid is high and its comma flag is low. Lane k uses bits [10k+9:10k] of the data buses and bit k of the per-lane flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for inputs and aligned outputs |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_en | input | 1 | Lock mode enable; low gives independent pass-through |
| freeze | input | 1 | Blocks the start of a new skew measurement |
| in_data | input | 40 | Four 10-bit lane characters |
| in_valid | input | 4 | Per-lane character valid |
| in_comma | input | 4 | Per-lane comma character flag |
| in_first | input | 4 | Per-lane marker on the first data character after commas |
| out_data | output | 40 | Four aligned 10-bit characters |
| out_valid | output | 4 | Per-lane valid, delayed with the data |
| deskew_ok | output | 1 | High while the lanes are aligned |
| deskew_fail | output | 1 | One-cycle pulse when the window expires |

## Verification
The bench builds the block with four 10-bit lanes, an 8-entry delay line per lane and a 5-cycle window. With these values a spread of exactly four cycles uses tap four, and a spread of five or six cycles crosses the window limit, so both sides of the boundary are covered. The 8-entry depth leaves unused taps above the window. Random skews between 0 and 6 and occasional freeze rounds add to directed patterns: equal arrival, maximum spread, overflow of the window, markers after lock, and lock mode off.

// File: rtl/deskew_pkg.sv
// Package: shared types for the four-lane deskew aligner.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package deskew_pkg;

    // Skew measurement controller state.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MEAS   = 2'd1,
        ST_LOCKED = 2'd2
    } meas_state_t;

endpackage

// File: rtl/lane_delay.sv
// Module: lane_delay
// A tapped delay line for one lane. Every cycle, the character and its valid
// bit enter tap 0 and all taps shift by one. The output is taken from the tap
// chosen by tap_sel, so the total latency is 1 + tap_sel cycles.
// Assumes: DEPTH is a power of two, so every tap_sel value addresses a tap.
module lane_delay #(
    parameter int W     = 10,
    parameter int DEPTH = 8,
    localparam int SEL_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     in_data,
    input  logic             in_valid,
    input  logic [SEL_W-1:0] tap_sel,
    output logic [W-1:0]     out_data,
    output logic             out_valid
);

    logic [W-1:0]     tap_d [DEPTH];
    logic [DEPTH-1:0] tap_v;

    // Shift the characters and valid bits one tap per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++) begin
                tap_d[j] <= '0;
            end
            tap_v <= '0;
        end else begin
            tap_d[0] <= in_data;
            tap_v[0] <= in_valid;
            for (int j = 1; j < DEPTH; j++) begin
                tap_d[j] <= tap_d[j-1];
                tap_v[j] <= tap_v[j-1];
            end
        end
    end

    // Select the output tap.
    always_comb begin
        out_data  = tap_d[tap_sel];
        out_valid = tap_v[tap_sel];
    end

    // R1 / R9: at minimum delay, the output is last cycle's input.
    a_r1_min_latency: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && tap_sel == '0) |-> (out_data == $past(in_data) && out_valid == $past(in_valid)));

endmodule

// File: rtl/skew_meas.sv
// Module: skew_meas
// Watches the per-lane first-data markers and measures each lane's arrival
// offset from the earliest one. When all lanes have reported within WINDOW
// cycles, it loads the tap selections and declares alignment. If the window
// runs out first, it pulses a failure and keeps the old tap selections.
// Assumes: markers are qualified (valid and not comma) by the caller.
module skew_meas
    import deskew_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int WINDOW    = 5,
    parameter int DEPTH_W   = 3,
    localparam int CNT_W    = $clog2(WINDOW + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         lock_en,
    input  logic                         freeze,
    input  logic [NUM_LANES-1:0]         first_q,
    output logic [NUM_LANES*DEPTH_W-1:0] tap_sel,
    output logic                         ok,
    output logic                         fail
);

    meas_state_t           st_q, st_nx;
    logic [CNT_W-1:0]      cnt_q, cnt_nx, cur_cnt;
    logic [NUM_LANES-1:0]  seen_q, seen_nx;
    logic [CNT_W-1:0]      off_q  [NUM_LANES];
    logic [CNT_W-1:0]      off_nx [NUM_LANES];
    logic [DEPTH_W-1:0]    dep_q  [NUM_LANES];
    logic [DEPTH_W-1:0]    dep_nx [NUM_LANES];
    logic                  active, all_seen, ok_nx, fail_nx;

    // Next-state logic: record arrivals, detect completion or timeout.
    always_comb begin
        cur_cnt  = (st_q == ST_MEAS) ? cnt_q : '0;
        active   = lock_en && ((st_q == ST_MEAS) ||
                   (st_q == ST_IDLE && !freeze && (|first_q)));
        seen_nx  = seen_q | first_q;
        all_seen = &seen_nx;
        st_nx    = st_q;
        cnt_nx   = cnt_q;
        ok_nx    = ok;
        fail_nx  = 1'b0;
        for (int i = 0; i < NUM_LANES; i++) begin
            off_nx[i] = (!seen_q[i] && first_q[i]) ? cur_cnt : off_q[i];
            dep_nx[i] = dep_q[i];
        end
        if (!lock_en) begin
            st_nx   = ST_IDLE;
            ok_nx   = 1'b0;
            seen_nx = '0;
            for (int i = 0; i < NUM_LANES; i++) begin
                dep_nx[i] = '0;
            end
        end else if (active && all_seen) begin
            st_nx = ST_LOCKED;
            ok_nx = 1'b1;
            for (int i = 0; i < NUM_LANES; i++) begin
                dep_nx[i] = DEPTH_W'(cur_cnt - off_nx[i]);
            end
        end else if (active && cur_cnt == CNT_W'(WINDOW - 1)) begin
            st_nx   = ST_IDLE;
            fail_nx = 1'b1;
            seen_nx = '0;
        end else if (active) begin
            st_nx  = ST_MEAS;
            cnt_nx = cur_cnt + 1'b1;
        end else begin
            seen_nx = seen_q;
        end
    end

    // State, offsets and tap selections registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            seen_q <= '0;
            ok     <= 1'b0;
            fail   <= 1'b0;
            for (int i = 0; i < NUM_LANES; i++) begin
                off_q[i] <= '0;
                dep_q[i] <= '0;
            end
        end else begin
            st_q   <= st_nx;
            cnt_q  <= cnt_nx;
            seen_q <= (st_nx == ST_MEAS) ? seen_nx : '0;
            ok     <= ok_nx;
            fail   <= fail_nx;
            for (int i = 0; i < NUM_LANES; i++) begin
                off_q[i] <= off_nx[i];
                dep_q[i] <= dep_nx[i];
            end
        end
    end

    // Flatten the tap selections per lane.
    generate
        for (genvar g = 0; g < NUM_LANES; g++) begin : g_sel
            assign tap_sel[g*DEPTH_W +: DEPTH_W] = dep_q[g];

            // R2 / R3: a chosen tap never exceeds the window spread.
            a_r3_tap_in_window: assert property (@(posedge clk) disable iff (!rst_n)
                dep_q[g] < DEPTH_W'(WINDOW));
        end
    endgenerate

    // R4: a failure indication lasts exactly one cycle.
    a_r4_fail_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> !fail);

    // R3 / R4: success and failure never coincide.
    a_r3_ok_fail_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok && fail));

    // R5: taps are held while aligned and lock mode stays on.
    a_r5_taps_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOCKED && lock_en) |=> ($stable(tap_sel) && ok));

    // R4: a timeout leaves the taps as they were.
    a_r4_taps_kept: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> $stable(tap_sel));

    // R7: freeze in idle keeps the controller idle.
    a_r7_freeze_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && freeze) |=> st_q == ST_IDLE);

endmodule

// File: rtl/quad_lane_deskew.sv
// Module: quad_lane_deskew (top)
// Four lanes, each with a tapped delay line, plus a skew measurement
// controller that picks the taps so that the lanes' first data characters
// leave together. All outputs are timed by clk.
// Assumes: lanes arrive already character-aligned on the same clock, and
// FIFO_DEPTH is at least WINDOW so that the largest tap exists.
module quad_lane_deskew
    import deskew_pkg::*;
#(
    parameter int NUM_LANES  = 4,
    parameter int CHAR_W     = 10,
    parameter int FIFO_DEPTH = 8,
    parameter int WINDOW     = 5,
    localparam int DEPTH_W   = $clog2(FIFO_DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        lock_en,
    input  logic                        freeze,
    input  logic [NUM_LANES*CHAR_W-1:0] in_data,
    input  logic [NUM_LANES-1:0]        in_valid,
    input  logic [NUM_LANES-1:0]        in_comma,
    input  logic [NUM_LANES-1:0]        in_first,
    output logic [NUM_LANES*CHAR_W-1:0] out_data,
    output logic [NUM_LANES-1:0]        out_valid,
    output logic                        deskew_ok,
    output logic                        deskew_fail
);

    logic [NUM_LANES-1:0]         first_q;
    logic [NUM_LANES*DEPTH_W-1:0] tap_sel;

    // Qualify the markers: only valid, non-comma characters count.
    always_comb begin
        first_q = in_first & in_valid & ~in_comma;
    end

    skew_meas #(
        .NUM_LANES (NUM_LANES),
        .WINDOW    (WINDOW),
        .DEPTH_W   (DEPTH_W)
    ) u_meas (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock_en (lock_en),
        .freeze  (freeze),
        .first_q (first_q),
        .tap_sel (tap_sel),
        .ok      (deskew_ok),
        .fail    (deskew_fail)
    );

    generate
        for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
            lane_delay #(
                .W     (CHAR_W),
                .DEPTH (FIFO_DEPTH)
            ) u_delay (
                .clk       (clk),
                .rst_n     (rst_n),
                .in_data   (in_data[g*CHAR_W +: CHAR_W]),
                .in_valid  (in_valid[g]),
                .tap_sel   (tap_sel[g*DEPTH_W +: DEPTH_W]),
                .out_data  (out_data[g*CHAR_W +: CHAR_W]),
                .out_valid (out_valid[g])
            );
        end
    endgenerate

    // R6: dropping lock mode clears the aligned flag on the next cycle.
    a_r6_lock_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_en |=> (!deskew_ok && tap_sel == '0));

    // R1: without lock mode, no alignment is ever declared.
    a_r1_no_ok_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(lock_en)) |-> !deskew_ok);

endmodule

// File: tb/test_quad_lane_deskew.sv
module test_quad_lane_deskew;
    localparam int NL = 4;
    localparam int CW = 10;
    localparam int HN = 4096;
    localparam logic [CW-1:0] COMMA = 10'h17C;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n, lock_en, freeze;
    logic [NL*CW-1:0]  in_data, out_data;
    logic [NL-1:0]     in_valid, in_comma, in_first, out_valid;
    logic              deskew_ok, deskew_fail;

    quad_lane_deskew #(.NUM_LANES(NL), .CHAR_W(CW), .FIFO_DEPTH(8), .WINDOW(5)) i_quad_lane_deskew (
        .clk(clk), .rst_n(rst_n), .lock_en(lock_en), .freeze(freeze),
        .in_data(in_data), .in_valid(in_valid), .in_comma(in_comma), .in_first(in_first),
        .out_data(out_data), .out_valid(out_valid),
        .deskew_ok(deskew_ok), .deskew_fail(deskew_fail)
    );

    int tests = 0, fails = 0, n = 0;
    bit done = 0;
    logic [CW-1:0] hd [NL][HN];
    logic          hv [NL][HN];
    int            md [NL];
    int            chk_from = 0;
    bit            chk_on = 0;
    string         cur_req = "R1";
    logic [CW-1:0] cd [NL];
    logic          cv [NL], cc [NL], cf [NL];

    task automatic check(input bit good, input string req, input int act, input int exp);
        tests++;
        if (!good) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, n);
        end
    endtask

    task automatic set_idle();
        for (int i = 0; i < NL; i++) begin
            cd[i] = '0; cv[i] = 1'b0; cc[i] = 1'b0; cf[i] = 1'b0;
        end
    endtask

    // Expected output for lane i at sample index s with model delay d.
    function automatic int exp_word(input int i, input int s, input int d);
        int k = s - 1 - d;
        return {21'd0, hv[i][k], hd[i][k]};
    endfunction

    // Sample outputs (away from the edge), compare, then drive next inputs.
    task automatic step();
        @(negedge clk);
        if (chk_on && n >= chk_from) begin
            for (int i = 0; i < NL; i++) begin
                if (n - 1 - md[i] >= 0) begin
                    check({out_valid[i], out_data[i*CW +: CW]} === {hv[i][n-1-md[i]], hd[i][n-1-md[i]]},
                          {cur_req, " R9 lane data"}, {21'd0, out_valid[i], out_data[i*CW +: CW]},
                          exp_word(i, n, md[i]));
                end
            end
        end
        for (int i = 0; i < NL; i++) begin
            in_data[i*CW +: CW] = cd[i];
            in_valid[i] = cv[i];
            in_comma[i] = cc[i];
            in_first[i] = cf[i];
            hd[i][n] = cd[i];
            hv[i][n] = cv[i];
        end
        n++;
    endtask

    task automatic run_round(input int s [NL], input bit lk, input bit fz, input bit rekick);
        int smin = 99, smax = 0, base, tlock, len;
        bit exp_ok, ok_seen = 0, fail_seen = 0, ok_early = 0;
        logic [CW-1:0] firstc [NL];
        chk_on = 0;
        lock_en = 1'b0; freeze = 1'b0;
        set_idle();
        step(); step();
        lock_en = lk; freeze = fz;
        foreach (s[i]) begin
            if (s[i] < smin) smin = s[i];
            if (s[i] > smax) smax = s[i];
        end
        exp_ok = lk && !fz && (smax - smin <= 4);
        base  = n + 3;
        tlock = base + smax;
        for (int i = 0; i < NL; i++) md[i] = exp_ok ? (smax - s[i]) : 0;
        if (exp_ok) begin chk_from = tlock + 1; cur_req = "R2"; end
        else begin chk_from = n; cur_req = !lk ? "R1" : (fz ? "R7" : "R4"); end
        if (rekick) cur_req = "R5";
        chk_on = 1;
        len = 3 + smax + 12;
        for (int c = 0; c < len; c++) begin
            int abs_i = n;
            for (int i = 0; i < NL; i++) begin
                cv[i] = 1'b1;
                cf[i] = 1'b0;
                if (abs_i < base + s[i]) begin
                    cd[i] = COMMA; cc[i] = 1'b1;
                end else begin
                    cd[i] = CW'($urandom % 1024); cc[i] = 1'b0;
                    if (abs_i == base + s[i]) begin cf[i] = 1'b1; firstc[i] = cd[i]; end
                    if (rekick && exp_ok && abs_i == tlock + 3 + i) cf[i] = 1'b1;
                end
            end
            step();
            if (deskew_fail) fail_seen = 1;
            if (deskew_ok) ok_seen = 1;
            if (exp_ok && abs_i <= tlock && deskew_ok) ok_early = 1;
            if (exp_ok && abs_i == tlock + 1) begin
                check(deskew_ok === 1'b1, "R3 ok rises with aligned data", deskew_ok, 1);
                for (int i = 0; i < NL; i++)
                    check(out_data[i*CW +: CW] === firstc[i], "R2 first data aligned",
                          out_data[i*CW +: CW], firstc[i]);
            end
            if (rekick && exp_ok && abs_i > tlock + 1)
                check(deskew_ok === 1'b1, "R5 ok held", deskew_ok, 1);
        end
        if (exp_ok) begin
            check(!ok_early, "R3 ok not early", ok_early, 0);
            check(!fail_seen, "R3 no fail on success", fail_seen, 0);
            // Drop lock mode: next sample shows ok low and minimum delay.
            chk_on = 0;
            lock_en = 1'b0;
            set_idle();
            step();
            check(deskew_ok === 1'b0, "R6 ok cleared", deskew_ok, 0);
            for (int i = 0; i < NL; i++) md[i] = 0;
            chk_from = n; cur_req = "R6"; chk_on = 1;
            for (int c = 0; c < 4; c++) begin
                for (int i = 0; i < NL; i++) begin cd[i] = CW'($urandom % 1024); cv[i] = 1'b1; end
                step();
            end
        end else begin
            check(!ok_seen, {cur_req, " ok stays low"}, ok_seen, 0);
            if (lk && !fz) check(fail_seen, "R4 fail pulse seen", fail_seen, 1);
            else check(!fail_seen, {cur_req, " no fail pulse"}, fail_seen, 0);
        end
        chk_on = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    initial begin
        int s [NL];
        void'($urandom(32'd4242));
        rst_n = 1'b0; lock_en = 1'b0; freeze = 1'b0;
        in_data = '0; in_valid = '0; in_comma = '0; in_first = '0;
        set_idle();
        for (int i = 0; i < NL; i++) cd[i] = 10'h3FF;
        for (int i = 0; i < NL; i++) cv[i] = 1'b1;
        step(); step(); step();
        // R8: reset state.
        check(out_data === '0, "R8 reset data", int'(out_data[31:0]), 0);
        check(out_valid === '0, "R8 reset valid", out_valid, 0);
        check(deskew_ok === 1'b0 && deskew_fail === 1'b0, "R8 reset flags", {deskew_ok, deskew_fail}, 0);
        rst_n = 1'b1;
        set_idle();
        step();

        s = '{0, 0, 0, 0};  run_round(s, 1, 0, 0);   // R2: equal arrival
        s = '{0, 1, 2, 4};  run_round(s, 1, 0, 0);   // R3: spread 4
        s = '{4, 0, 3, 1};  run_round(s, 1, 0, 0);   // R3: spread 4, other order
        s = '{1, 6, 2, 3};  run_round(s, 1, 0, 0);   // R4: spread 5
        s = '{0, 2, 6, 1};  run_round(s, 1, 0, 0);   // R4: spread 6
        s = '{2, 0, 1, 3};  run_round(s, 1, 0, 1);   // R5: markers after lock
        s = '{0, 3, 1, 2};  run_round(s, 0, 0, 0);   // R1: lock mode off
        s = '{0, 1, 1, 2};  run_round(s, 1, 1, 0);   // R7: freeze
        for (int r = 0; r < 14; r++) begin
            for (int i = 0; i < NL; i++) s[i] = int'($urandom % 7);
            run_round(s, 1, ($urandom % 5) == 0, ($urandom % 2) == 0);
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule